// File: doc/BRIEF.md
# Auto-Increment I2C Configuration Register Target

This block is an I2C target that exposes thirty-two 8-bit configuration registers (pointer values 00h to 1Fh) to a bus controller. It answers only at the fixed 7-bit address 6Eh, which makes the address byte DCh for writes and DDh for reads. An active-low enable input lets a board put several copies on one bus and address them one at a time. A write transfer first loads an internal register pointer and then stores any further bytes at successive pointer values. The pointer is kept between transfers, so a read is done in two steps: a short write that carries only the pointer, then a read transfer that streams bytes from that pointer until the controller answers a byte with NACK.

The register contents are visible in parallel on a flat output bus for the rest of the chip. Register 01h mixes writable control bits with three live status inputs. The high bytes of the multi-byte fields have hardwired zero bits. The block of registers from 15h up is reserved: it reads zero and ignores writes. A rising write of the init bit in register 0Ah produces a one-cycle strobe. SCL and SDA are brought into the system clock domain through two-flop synchronisers. START and STOP are decoded from SDA edges seen while SCL is high.

The protocol engine is a state machine with eight states.
- S_IDLE waits for a START.
- S_ADDR shifts in the address byte. On the eighth falling SCL edge it goes to S_ADDR_ACK if the address matches and to S_IGNORE if it does not.
- S_ADDR_ACK pulls SDA for the ninth clock. It then moves to S_WR_BYTE for a write or to S_RD_BYTE for a read.
- S_WR_BYTE receives a byte and moves to S_WR_ACK. S_WR_ACK acknowledges that byte and returns to S_WR_BYTE.
- S_RD_BYTE drives a byte and moves to S_RD_ACK. S_RD_ACK samples the controller's acknowledge. It returns to S_RD_BYTE on ACK and goes to S_IGNORE on NACK.
- S_IGNORE waits for the next START or STOP.
- From any state, a START goes to S_ADDR, and a STOP or a high enable input goes to S_IDLE.

Top module: `cfg_i2c_target`

## Requirements
- R1: The address byte DCh (write) and DDh (read) is acknowledged. Any other address byte is not acknowledged, and the bytes that follow it up to the next START or STOP change nothing.
- R2: While `en_n` is high, the block never pulls SDA and no transfer changes any register.
- R3: In a write transfer, the first byte after the address sets the pointer to its bits 4:0. Each later byte is stored at the pointer, and the pointer then increments, wrapping from 1Fh to 00h.
- R4: A read transfer returns the register at the pointer and increments the pointer per byte, continuing while the controller acknowledges. The pointer keeps its value across transfers.
- R5: Every byte the block accepts (address, pointer, data) is acknowledged by pulling SDA low through the ninth clock. The block changes its SDA drive only while SCL is low, and releases SDA after a NACKed read byte.
- R6: After reset, registers 00h=A3h, 01h=86h, 03h=01h, 04h=B4h, 05h=06h, 08h=04h, 09h=01h, 0Dh=0Dh, 0Eh=02h, 13h=88h, 14h=88h, and every other register is 00h. Bits 2:0 of 01h reflect the status input, so this value holds with status 110b.
- R7: Bits 2:0 of register 01h always show `status_i[2:0]`. A write to 01h changes only bits 7:3.
- R8: Bits 7:5 of 05h and 0Ch and bits 7:4 of 0Eh, 10h and 12h always read zero. Registers 15h to 1Fh read 00h and ignore writes.
- R9: A write that sets bit 5 of register 0Ah when it was 0 raises `init_pulse_o` for exactly one clock. A write that leaves that bit at 1, or clears it, gives no pulse.
- R10: A START in the middle of a transfer, including one in the middle of a byte, restarts address reception.
- R11: Register n is presented on `regs_o[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| en_n | input | 1 | Active-low target enable |
| status_i | input | 3 | Live status bits shown in register 01h bits 2:0 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain control) |
| regs_o | output | 256 | All registers, register n at bits 8n+7:8n |
| init_pulse_o | output | 1 | One-cycle strobe on a rising write of 0Ah bit 5 |

## Verification
The hardest situations to reach from the ports are a pointer that wraps from 1Fh into the reserved region and back to 00h in one burst, and a START that cuts a byte off half way. The bench reaches both with directed bus sequences. One burst starts at pointer 1Eh. In another sequence the bit-level driver sends four data bits and then issues a START before the byte ends. A bench-side register model, updated only from the written masks and pointer rules, predicts every read-back. Pointer persistence is checked by a second read transfer that must continue where the first one stopped.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int BYTE_W     = 8;
    localparam int STATUS_REG = 1;
    localparam int STATUS_W   = 3;
    localparam int INIT_REG   = 10;
    localparam int INIT_BIT   = 5;
    localparam int RSV_FIRST  = 21;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BYTE,
        S_WR_ACK,
        S_RD_BYTE,
        S_RD_ACK,
        S_IGNORE
    } tgt_state_e;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hA3;
            1:       return 8'h86;
            3:       return 8'h01;
            4:       return 8'hB4;
            5:       return 8'h06;
            8:       return 8'h04;
            9:       return 8'h01;
            13:      return 8'h0D;
            14:      return 8'h02;
            19:      return 8'h88;
            20:      return 8'h88;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
        if (idx >= RSV_FIRST) return 8'h00;
        case (idx)
            STATUS_REG:   return 8'hF8;
            5, 12:        return 8'h1F;
            14, 16, 18:   return 8'h0F;
            default:      return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NREGS  = 32,
    parameter int ADDR_W = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [STATUS_W-1:0]      status_i,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NREGS*BYTE_W-1:0]  regs_o,
    output logic                     init_pulse
);
    logic [BYTE_W-1:0] q    [NREGS];
    logic [BYTE_W-1:0] view [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] DEF = reg_default(g);
        localparam logic [BYTE_W-1:0] MSK = reg_wmask(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[g] <= DEF;
            else if (wr_en && wr_addr == ADDR_W'(g))
                q[g] <= (wr_data & MSK) | (q[g] & ~MSK);
        end

        if (g == STATUS_REG) begin : g_status
            assign view[g] = {q[g][BYTE_W-1:STATUS_W], status_i};
        end else begin : g_plain
            assign view[g] = q[g];
        end

        assign regs_o[g*BYTE_W +: BYTE_W] = view[g];
    end

    assign rd_data = view[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            init_pulse <= 1'b0;
        else
            init_pulse <= wr_en && wr_addr == ADDR_W'(INIT_REG)
                          && wr_data[INIT_BIT] && !q[INIT_REG][INIT_BIT];
    end

    // R9: the init strobe never lasts two cycles
    p_init_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    // R8: reserved registers keep their value across a write aimed at them
    p_reserved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(RSV_FIRST))
        |=> $stable(regs_o[NREGS*BYTE_W-1:RSV_FIRST*BYTE_W]));
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E,
    parameter int         ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    tgt_state_e        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] ptr;
    logic              rw_q, ptr_pend, mack_q, pull_raw;
    logic              byte_done, addr_hit;

    assign byte_done = (bit_cnt == LAST_BIT);
    assign addr_hit  = (shreg[BYTE_W-1:1] == DEV_ADDR);

    // next-state logic
    always_comb begin
        nxt = state;
        if (en_n || bus_stop)
            nxt = S_IDLE;
        else if (bus_start)
            nxt = S_ADDR;
        else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_ADDR:     if (scl_fall && byte_done) nxt = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall) nxt = rw_q ? S_RD_BYTE : S_WR_BYTE;
                S_WR_BYTE:  if (scl_fall && byte_done) nxt = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) nxt = S_WR_BYTE;
                S_RD_BYTE:  if (scl_fall && byte_done) nxt = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) nxt = mack_q ? S_RD_BYTE : S_IGNORE;
                S_IGNORE:   nxt = S_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath: shifter, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            ptr_pend <= 1'b0;
            mack_q   <= 1'b0;
        end else if (en_n || bus_start) begin
            bit_cnt <= '0;
        end else if (!bus_stop) begin
            case (state)
                S_ADDR: begin
                    if (scl_rise && !byte_done) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_done) rw_q <= shreg[0];
                end
                S_ADDR_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (rw_q) begin
                        shreg <= rd_data;
                        ptr   <= ptr + 1'b1;
                    end else begin
                        ptr_pend <= 1'b1;
                    end
                end
                S_WR_BYTE: begin
                    if (scl_rise && !byte_done) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && byte_done) begin
                        if (ptr_pend) begin
                            ptr      <= shreg[ADDR_W-1:0];
                            ptr_pend <= 1'b0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                S_WR_ACK: if (scl_fall) bit_cnt <= '0;
                S_RD_BYTE: begin
                    if (scl_rise && !byte_done) bit_cnt <= bit_cnt + 1'b1;
                    if (scl_fall && !byte_done) shreg <= {shreg[BYTE_W-2:0], 1'b0};
                end
                S_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_q) begin
                            shreg <= rd_data;
                            ptr   <= ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_WR_ACK: pull_raw = 1'b1;
            S_RD_BYTE:            pull_raw = ~shreg[BYTE_W-1];
            default:              pull_raw = 1'b0;
        endcase
    end

    assign sda_pull = pull_raw & ~en_n;
    assign wr_en    = (state == S_WR_BYTE) && scl_fall && byte_done && !ptr_pend
                      && !en_n && !bus_stop && !bus_start;
    assign wr_addr  = ptr;
    assign wr_data  = shreg;
    assign rd_addr  = ptr;

    // R2: a disabled target leaves the protocol and stops driving
    p_quiet_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !pull_raw);

    // R5: SDA drive only moves while SCL is low
    p_sda_hold_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !$past(en_n) && scl_s && $past(scl_s)) |-> $stable(sda_pull));

    // R3: every stored byte advances the pointer by one, with wrap
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr == $past(wr_addr) + {{(ADDR_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int         NREGS       = 32,
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    en_n,
    input  logic [STATUS_W-1:0]     status_i,
    output logic                    sda_pull_o,
    output logic [NREGS*BYTE_W-1:0] regs_o,
    output logic                    init_pulse_o
);
    localparam int ADDR_W = $clog2(NREGS);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull(sda_pull_o)
    );

    cfg_reg_bank #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .regs_o(regs_o), .init_pulse(init_pulse_o)
    );
endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
    localparam int Q = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         en_n = 1'b0;
    logic [2:0]   status = 3'b110;
    logic         sda_pull, init_pulse;
    logic [255:0] regs;
    logic         sda_line;

    int n_tests = 0, n_fail = 0;
    int init_cnt = 0, wide_err = 0, dis_err = 0;
    logic prev_init = 1'b0;
    bit done = 0;

    logic [7:0] mdl [32];
    logic [4:0] mptr = '0;

    assign sda_line = m_sda & ~sda_pull;

    always #10 clk = ~clk;

    cfg_i2c_target i_cfg_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .en_n(en_n),
        .status_i(status), .sda_pull_o(sda_pull), .regs_o(regs), .init_pulse_o(init_pulse)
    );

    always @(negedge clk) begin
        if (init_pulse) begin
            init_cnt++;
            if (prev_init) wide_err++;
        end
        prev_init = init_pulse;
        if (en_n && sda_pull) dis_err++;
    end

    function automatic logic [7:0] exp_def(input int i);
        case (i)
            0: return 8'hA3;  1: return 8'h86;  3: return 8'h01;  4: return 8'hB4;
            5: return 8'h06;  8: return 8'h04;  9: return 8'h01;  13: return 8'h0D;
            14: return 8'h02; 19: return 8'h88; 20: return 8'h88;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_mask(input int i);
        if (i >= 21) return 8'h00;
        case (i)
            1: return 8'hF8;
            5, 12: return 8'h1F;
            14, 16, 18: return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] vis(input int i);
        return (i == 1) ? {mdl[1][7:3], status} : mdl[i];
    endfunction

    function automatic logic [7:0] rg(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); scl = 1'b1; qw(); m_sda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); scl = 1'b1; qw(); m_sda = 1'b1; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(~give_ack);
    endtask

    task automatic model_store(input logic [7:0] d);
        logic [7:0] m;
        m = exp_mask(int'(mptr));
        mdl[mptr] = (d & m) | (mdl[mptr] & ~m);
        mptr = mptr + 1'b1;
    endtask

    // write transfer: pointer then n data bytes packed in dd (byte k at dd[8k+:8])
    task automatic wr_seq(input logic [7:0] ptr, input int n, input logic [31:0] dd);
        logic a;
        bus_start();
        wbyte(8'hDC, a);  chk("R1 write address ack", a, 1);
        wbyte(ptr, a);    chk("R5 pointer ack", a, 1);
        mptr = ptr[4:0];
        for (int k = 0; k < n; k++) begin
            wbyte(dd[8*k +: 8], a);
            chk("R5 data ack", a, 1);
            model_store(dd[8*k +: 8]);
        end
        bus_stop();
    endtask

    task automatic rd_seq(input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(8'hDD, a);  chk("R1 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, d);
            chk("R4 read data", d, vis(int'(mptr)));
            mptr = mptr + 1'b1;
        end
        chk("R5 SDA released after NACK", sda_line, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) begin
            mdl[i] = exp_def(i);
            chk($sformatf("R6 R11 reset reg %0d", i), rg(i), exp_def(i));
        end
        chk("R5 idle line high", sda_line, 1);
    endtask

    task automatic t_burst();
        wr_seq(8'h11, 4, 32'h29_C7_F3_5A);
        chk("R3 burst 11h", rg(17), 8'h5A);
        chk("R8 burst 12h masked", rg(18), 8'h03);
        chk("R3 burst 13h", rg(19), 8'hC7);
        chk("R3 burst 14h", rg(20), 8'h29);
    endtask

    task automatic t_wrap();
        wr_seq(8'h1E, 3, 32'h00_55_66_77);
        chk("R8 reserved 1Eh", rg(30), 8'h00);
        chk("R8 reserved 1Fh", rg(31), 8'h00);
        chk("R3 wrap to 00h", rg(0), 8'h55);
    endtask

    task automatic t_masks();
        wr_seq(8'h0C, 4, 32'hFF_FF_FF_FF);
        wr_seq(8'h04, 2, 32'h0000_FFFF);
        wr_seq(8'h10, 1, 32'h0000_00FF);
        chk("R8 0Ch", rg(12), 8'h1F);
        chk("R3 0Dh", rg(13), 8'hFF);
        chk("R8 0Eh", rg(14), 8'h0F);
        chk("R3 0Fh", rg(15), 8'hFF);
        chk("R3 04h", rg(4), 8'hFF);
        chk("R8 05h", rg(5), 8'h1F);
        chk("R8 10h", rg(16), 8'h0F);
    endtask

    task automatic t_status();
        status = 3'b010;
        wr_seq(8'h01, 1, 32'h0000_00FF);
        chk("R7 ctrl bits with status 010", rg(1), 8'hFA);
        status = 3'b101;
        repeat (2) @(negedge clk);
        chk("R7 status follows input", rg(1), 8'hFD);
        wr_seq(8'h01, 0, 32'h0);
        rd_seq(1);
    endtask

    task automatic t_read();
        wr_seq(8'h0D, 0, 32'h0);
        rd_seq(3);
        rd_seq(2);   // continues at 10h: pointer persists
        chk("R4 pointer after reads", {27'h0, mptr}, 32'h12);
    endtask

    task automatic t_badaddr();
        logic a;
        logic [7:0] before5;
        before5 = rg(5);
        bus_start();
        wbyte(8'hA0, a); chk("R1 foreign address NACK", a, 0);
        wbyte(8'h05, a); chk("R1 ignored byte NACK", a, 0);
        wbyte(8'h99, a);
        bus_stop();
        bus_start();
        wbyte(8'hDE, a); chk("R1 near address NACK", a, 0);
        bus_stop();
        chk("R1 register untouched", rg(5), before5);
    endtask

    task automatic t_disable();
        logic a;
        logic [7:0] before9;
        before9 = rg(9);
        en_n = 1'b1;
        bus_start();
        wbyte(8'hDC, a); chk("R2 disabled NACK", a, 0);
        wbyte(8'h09, a);
        wbyte(8'h42, a);
        bus_stop();
        chk("R2 register untouched", rg(9), before9);
        chk("R2 no SDA drive while disabled", dis_err, 0);
        en_n = 1'b0;
        qw();
    endtask

    task automatic t_rstart();
        logic a;
        logic [7:0] d;
        bus_start();
        wbyte(8'hDC, a);
        wbyte(8'h13, a);
        mptr = 5'h13;
        bus_start();
        wbyte(8'hDD, a); chk("R10 read after repeated START ack", a, 1);
        rbyte(1'b0, d);
        chk("R10 read at pointer 13h", d, vis(19));
        mptr = mptr + 1'b1;
        bus_stop();
        bus_start();
        wbyte(8'hDC, a);
        wbyte(8'h09, a);
        for (int i = 7; i >= 4; i--) send_bit(1'b1);
        bus_start();
        wbyte(8'hDC, a); chk("R10 address after cut byte ack", a, 1);
        wbyte(8'h09, a);
        mptr = 5'h09;
        wbyte(8'h3C, a);
        model_store(8'h3C);
        bus_stop();
        chk("R10 write after cut byte", rg(9), 8'h3C);
    endtask

    task automatic t_init();
        int c0;
        c0 = init_cnt;
        wr_seq(8'h0A, 1, 32'h20);
        chk("R9 rising init bit pulses", init_cnt - c0, 1);
        wr_seq(8'h0A, 1, 32'h20);
        chk("R9 init bit already set no pulse", init_cnt - c0, 1);
        wr_seq(8'h0A, 1, 32'h00);
        chk("R9 clearing gives no pulse", init_cnt - c0, 1);
        wr_seq(8'h0A, 1, 32'h20);
        chk("R9 second rising pulse", init_cnt - c0, 2);
        chk("R9 pulse one cycle wide", wide_err, 0);
        chk("R3 0Ah stored", rg(10), 8'h20);
    endtask

    task automatic t_full_compare();
        for (int i = 0; i < 32; i++)
            chk($sformatf("R11 final reg %0d", i), rg(i), vis(i));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_burst();
        t_wrap();
        t_masks();
        t_status();
        t_read();
        t_badaddr();
        t_disable();
        t_rstart();
        t_init();
        t_full_compare();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule